// File: doc/BRIEF.md
# Interrupt Controller with Skip Polling

This block is the interrupt logic beside a small 4-bit processor core. It has three interrupt sources: an external event (source 0), timer 1 (source 1) and timer 2 (source 2). Each source's event pulse sets a request flag, and the flag stays set until something consumes it. The block holds a global enable flag that the core's enable and disable instructions drive. It also holds a 4-bit control register that carries one enable bit per source plus one spare bit. The core loads this register from its accumulator and reads it back.

At each instruction boundary the block decides whether to accept an interrupt. If it accepts one, it signals the accept and gives the winning source's index. Accepting an interrupt clears the global enable, so software must enable again to take a further interrupt. After an enable instruction there is a delay of one instruction: the boundary that ends the enable instruction cannot accept, and the boundary after it can. Software that keeps a source's interrupt disabled can poll that source with a skip-test instruction instead. The block answers in the same cycle whether the instruction skips, and a skip consumes the request.

All outputs are plain control signals. The accept indication is a one-cycle strobe that the core takes at its boundary. It has no valid/ready handshake, because the core always consumes an accept in the cycle it is raised.

Top module: `intr_skip_ctl`

## Requirements
- R1: A transfer-in strobe (`ctl_wr_i`) loads `acc_i` into the 4-bit control register at the clock edge. While `ctl_rd_i` is high, `ctl_rd_data_o` shows the register in the same cycle, and it is 0000 otherwise. Bit 1 has no function but holds and returns whatever was written.
- R2: Control register bit positions: bit 0 enables source 0 (external), bit 2 enables source 1 (timer 1), bit 3 enables source 2 (timer 2).
- R3: Reset clears the control register to 0000. Holding `pwr_down_i` high forces it to 0000 at the next edge, and this takes precedence over a write in the same cycle.
- R4: An event pulse on `evt_i[s]` sets request flag s at the next edge, whatever the global enable and the enable bits are. If an event and a clear of the same flag fall in one cycle, the flag ends up set.
- R5: In a cycle with `skip_test_i` high, `skip_o` is 1 exactly when the source selected by `skip_sel_i` (0, 1 or 2) has its flag set and its enable bit at 0. Selector value 3 never skips. A skip clears that flag at the next edge.
- R6: When the selected source's enable bit is 1, `skip_o` stays 0 and the source's flag is left unchanged.
- R7: An `ei_i` strobe sets the global enable and a `di_i` strobe clears it. A disable or an accept in the same cycle takes precedence over an enable.
- R8: After an `ei_i` strobe, the first boundary in that cycle or later cannot accept. Acceptance becomes possible from the boundary after it.
- R9: `irq_take_o` is high only in a cycle with `boundary_i` high, effective global enable, and some source with both its flag and its enable bit set. `irq_src_o` gives the lowest-numbered such source, and only that source's flag clears.
- R10: An accept clears the global enable, so no further accept occurs until a new `ei_i` and its delay have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down_i | input | 1 | Power-down entry; clears the control register |
| evt_i | input | 3 | Per-source event pulses (bit s = source s) |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| ctl_wr_i | input | 1 | Load control register from accumulator |
| acc_i | input | 4 | Accumulator value for the load |
| ctl_rd_i | input | 1 | Copy control register to accumulator |
| ctl_rd_data_o | output | 4 | Control register value while reading, else 0 |
| skip_test_i | input | 1 | Skip-on-request instruction strobe |
| skip_sel_i | input | 2 | Source tested by the skip instruction |
| skip_o | output | 1 | The skip instruction skips |
| boundary_i | input | 1 | Instruction boundary strobe |
| irq_take_o | output | 1 | Interrupt accepted at this boundary |
| irq_src_o | output | 2 | Accepted source index (0 when no accept) |

## Verification
`skip_o`, `irq_take_o`, `irq_src_o` and `ctl_rd_data_o` are combinational from the strobes and the registered state, so the bench checks them one time step after it drives the strobe, in the same cycle. Every state change (flag set, flag clear, register load, power-down clear, enable set or clear) shows up one edge later. The bench drives each stimulus at a falling edge and observes its effect in the following cycle through a skip test, a register read or a boundary. The delay after an enable is checked by counting boundaries in the bench. Flags that must survive or must clear are read back by polling them with the enable bits at 0.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NSRC  = 3;
  localparam int SRC_W = 2;
  localparam int CTL_W = 4;

  // bit position of each source's enable inside the control register
  function automatic int en_pos(input int src);
    case (src)
      0:       return 0;
      1:       return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg #(
  parameter int CTL_W = intr_pkg::CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down_i,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] rd_data_o
);
  // power-down clear outranks a load in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          ctl_q <= '0;
    else if (pwr_down_i) ctl_q <= '0;
    else if (wr_i)       ctl_q <= wr_data_i;
  end

  assign rd_data_o = rd_i ? ctl_q : '0;
endmodule

// File: rtl/intr_req_bank.sv
module intr_req_bank #(
  parameter int NSRC = intr_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_q
);
  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[s] <= 1'b0;
      else if (set_i[s]) flag_q[s] <= 1'b1;
      else if (clr_i[s]) flag_q[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int NSRC  = intr_pkg::NSRC,
  parameter int SRC_W = intr_pkg::SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             boundary_i,
  input  logic [NSRC-1:0]  pend_i,
  output logic             take_o,
  output logic [SRC_W-1:0] src_o,
  output logic [NSRC-1:0]  win_o
);
  logic ie_q;    // global enable
  logic hold_q;  // enable set, but the enabling instruction has not ended yet
  logic ie_eff;
  logic [SRC_W-1:0] src_c;
  logic [NSRC-1:0]  win_c;

  assign ie_eff = ie_q & ~hold_q;
  assign take_o = boundary_i & ie_eff & (|pend_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
    end else if (di_i || take_o) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
    end else if (ei_i) begin
      ie_q   <= 1'b1;
      hold_q <= ~boundary_i;
    end else if (boundary_i) begin
      hold_q <= 1'b0;
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    src_c = '0;
    win_c = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (pend_i[s]) begin
        src_c    = SRC_W'(s);
        win_c    = '0;
        win_c[s] = 1'b1;
      end
    end
  end

  assign src_o = take_o ? src_c : '0;
  assign win_o = take_o ? win_c : '0;
endmodule

// File: rtl/intr_skip_ctl.sv
module intr_skip_ctl #(
  parameter int NSRC  = intr_pkg::NSRC,
  parameter int SRC_W = intr_pkg::SRC_W,
  parameter int CTL_W = intr_pkg::CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down_i,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] acc_i,
  input  logic             ctl_rd_i,
  output logic [CTL_W-1:0] ctl_rd_data_o,
  input  logic             skip_test_i,
  input  logic [SRC_W-1:0] skip_sel_i,
  output logic             skip_o,
  input  logic             boundary_i,
  output logic             irq_take_o,
  output logic [SRC_W-1:0] irq_src_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [NSRC-1:0]  en_v;
  logic [NSRC-1:0]  flag_q;
  logic [NSRC-1:0]  sel_oh;
  logic [NSRC-1:0]  skip_clr;
  logic [NSRC-1:0]  win;
  logic [NSRC-1:0]  clr;

  intr_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down_i(pwr_down_i),
    .wr_i      (ctl_wr_i),
    .wr_data_i (acc_i),
    .rd_i      (ctl_rd_i),
    .ctl_q     (ctl_q),
    .rd_data_o (ctl_rd_data_o)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int P = intr_pkg::en_pos(s);
    assign en_v[s]   = ctl_q[P];
    assign sel_oh[s] = (skip_sel_i == SRC_W'(s));
  end

  // polling only counts for sources whose interrupt is disabled
  assign skip_clr = {NSRC{skip_test_i}} & sel_oh & ~en_v & flag_q;
  assign skip_o   = |skip_clr;
  assign clr      = skip_clr | win;

  intr_req_bank #(.NSRC(NSRC)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr),
    .flag_q(flag_q)
  );

  intr_gate #(.NSRC(NSRC), .SRC_W(SRC_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .boundary_i(boundary_i),
    .pend_i    (flag_q & en_v),
    .take_o    (irq_take_o),
    .src_o     (irq_src_o),
    .win_o     (win)
  );
endmodule

// File: rtl/intr_skip_ctl_chk.sv
module intr_skip_ctl_chk #(
  parameter int NSRC  = intr_pkg::NSRC,
  parameter int SRC_W = intr_pkg::SRC_W,
  parameter int CTL_W = intr_pkg::CTL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down_i,
  input logic [NSRC-1:0]  evt_i,
  input logic             ei_i,
  input logic             boundary_i,
  input logic             skip_test_i,
  input logic [SRC_W-1:0] skip_sel_i,
  input logic             skip_o,
  input logic             irq_take_o,
  input logic [SRC_W-1:0] irq_src_o,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  en_v,
  input logic [CTL_W-1:0] ctl_q
);
  logic [NSRC-1:0] sel_m;
  logic [NSRC-1:0] low_m;
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      sel_m[s] = (skip_sel_i == SRC_W'(s));
      low_m[s] = (SRC_W'(s) < irq_src_o);
    end
  end

  a_r3_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (ctl_q == '0));

  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  a_r6_enabled_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_test_i && ((en_v & sel_m) != '0)) |-> !skip_o);

  a_r8_ei_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_i && !boundary_i) |=> !irq_take_o);

  a_r9_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> boundary_i);

  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> ((flag_q & en_v & low_m) == '0));

  a_r10_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |=> !irq_take_o);
endmodule

bind intr_skip_ctl intr_skip_ctl_chk #(.NSRC(NSRC), .SRC_W(SRC_W), .CTL_W(CTL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down_i (pwr_down_i),
  .evt_i      (evt_i),
  .ei_i       (ei_i),
  .boundary_i (boundary_i),
  .skip_test_i(skip_test_i),
  .skip_sel_i (skip_sel_i),
  .skip_o     (skip_o),
  .irq_take_o (irq_take_o),
  .irq_src_o  (irq_src_o),
  .flag_q     (flag_q),
  .en_v       (en_v),
  .ctl_q      (ctl_q)
);

// File: tb/intr_skip_ctl_bench.sv
`timescale 1ns/1ps
module intr_skip_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic [2:0] evt = '0;
  logic       ei = 1'b0, di = 1'b0;
  logic       ctl_wr = 1'b0, ctl_rd = 1'b0;
  logic [3:0] acc = '0;
  logic [3:0] rd_data;
  logic       skip_test = 1'b0;
  logic [1:0] skip_sel = '0;
  logic       skip;
  logic       boundary = 1'b0;
  logic       take;
  logic [1:0] src;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_skip_ctl u_intr_skip_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down), .evt_i(evt),
    .ei_i(ei), .di_i(di), .ctl_wr_i(ctl_wr), .acc_i(acc), .ctl_rd_i(ctl_rd),
    .ctl_rd_data_o(rd_data), .skip_test_i(skip_test), .skip_sel_i(skip_sel),
    .skip_o(skip), .boundary_i(boundary), .irq_take_o(take), .irq_src_o(src)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // move to the next falling edge with every strobe released
  task automatic go();
    @(negedge clk);
    pwr_down = 0; evt = '0; ei = 0; di = 0; ctl_wr = 0; ctl_rd = 0;
    skip_test = 0; skip_sel = '0; boundary = 0;
  endtask

  task automatic wr_ctl(input int v);
    go(); ctl_wr = 1; acc = 4'(v);
  endtask

  task automatic poll(input int s, input int exp, input string req);
    go(); skip_test = 1; skip_sel = 2'(s); #1 chk(req, int'(skip), exp);
  endtask

  task automatic flush();
    wr_ctl(0);
    for (int s = 0; s < 3; s++) begin go(); skip_test = 1; skip_sel = 2'(s); end
  endtask

  function automatic int epos(input int s);
    return (s == 0) ? 0 : (s == 1) ? 2 : 3;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    go(); go();
    rst_n = 1;
    // reset state: R3
    go(); ctl_rd = 1; boundary = 1; skip_test = 1; skip_sel = 0;
    #1 chk("R3 reset ctl", int'(rd_data), 0);
    chk("R9 no take after reset", int'(take), 0);
    chk("R5 no skip after reset", int'(skip), 0);

    // R1: every register value, bit 1 included
    for (int v = 0; v < 16; v++) begin
      wr_ctl(v);
      go(); #1 chk("R1 read idle zero", int'(rd_data), 0);
      ctl_rd = 1; #1 chk("R1 readback", int'(rd_data), v);
    end
    // R3: power-down over a write
    wr_ctl(15);
    go(); pwr_down = 1; ctl_wr = 1; acc = 4'd6;
    go(); ctl_rd = 1; #1 chk("R3 power-down clear", int'(rd_data), 0);

    // R4/R5: every event subset against every selector
    for (int m = 0; m < 8; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        flush();
        go(); evt = 3'(m);
        poll(sel, (sel < 3) ? ((m >> sel) & 1) : 0, "R5 skip on flag");
        poll(sel, 0, "R5 skip cleared flag");
      end
    end

    // R2/R6: one enable bit at a time
    for (int s = 0; s < 3; s++) begin
      flush();
      wr_ctl(1 << epos(s));
      go(); evt = 3'b111;
      for (int t = 0; t < 3; t++)
        poll(t, (t == s) ? 0 : 1, (t == s) ? "R6 enabled no skip" : "R2 bit mapping");
      wr_ctl(0);
      poll(s, 1, "R6 flag kept while enabled");
    end
    // R1: spare bit 1 gates nothing
    flush(); wr_ctl(2);
    go(); evt = 3'b111;
    for (int t = 0; t < 3; t++) poll(t, 1, "R1 spare bit no function");

    // R4: set wins over skip clear
    flush();
    go(); evt = 3'b001;
    go(); skip_test = 1; skip_sel = 0; evt = 3'b001;
    #1 chk("R5 skip with event", int'(skip), 1);
    poll(0, 1, "R4 set wins over clear");

    // R9/R10: priority and winner-only clear for every flag subset
    for (int m = 1; m < 8; m++) begin
      int w;
      w = (m & 1) ? 0 : (m & 2) ? 1 : 2;
      flush(); wr_ctl(13);
      go(); evt = 3'(m);
      go(); ei = 1; boundary = 1;
      #1 chk("R8 no take at EI boundary", int'(take), 0);
      go(); boundary = 1;
      #1 chk("R9 take", int'(take), 1);
      chk("R9 source", int'(src), w);
      go(); boundary = 1;
      #1 chk("R10 auto clear", int'(take), 0);
      wr_ctl(0);
      for (int t = 0; t < 3; t++)
        poll(t, (((m >> t) & 1) == 1 && t != w) ? 1 : 0, "R9 only winner cleared");
    end

    // R8: EI strobe ahead of its boundary
    flush(); wr_ctl(13);
    go(); evt = 3'b100;
    go(); ei = 1;
    #1 chk("R8 no take in EI cycle", int'(take), 0);
    go(); boundary = 1; #1 chk("R8 EI own boundary", int'(take), 0);
    go(); boundary = 1; #1 chk("R8 next boundary takes", int'(take), 1);
    chk("R9 timer 2 source", int'(src), 2);

    // R7: DI, and DI beating EI
    go(); evt = 3'b010;
    go(); ei = 1; boundary = 1;
    go(); di = 1;
    go(); boundary = 1; #1 chk("R7 DI disables", int'(take), 0);
    go(); ei = 1; di = 1; boundary = 1;
    go(); boundary = 1; #1 chk("R7 DI over EI", int'(take), 0);
    go(); ei = 1; boundary = 1;
    go(); boundary = 1; #1 chk("R7 EI enables", int'(take), 1);
    chk("R9 timer 1 source", int'(src), 1);

    // R9: pending flag with enable bit 0 is not taken
    flush();
    go(); evt = 3'b001;
    go(); ei = 1; boundary = 1;
    go(); boundary = 1; #1 chk("R9 masked source not taken", int'(take), 0);

    go();
    finish_run();
  end
endmodule